// File: doc/BRIEF.md
# Burst-level SECDED error classifier

This block sits beside the read-return path of a memory whose check bits are stored next to the data. For each read burst it collects the outcome of the per-word single-error-correct / double-error-detect check and, when the burst closes, sorts the whole burst into one of three classes: clean, correctable or fatal. Correctable and fatal events raise their own level interrupts. The first fatal burst captures the burst address and a per-word error mask, and that record stays frozen until software acknowledges it.

If two or more words of one burst each show a single-bit error, the burst is not treated as several repairs. It is escalated to a fatal event, on the view that scattered single flips in one burst most likely hide wider damage. A burst that is restarted before its end strobe is thrown away without any report.

The burst controller has two states. `ST_IDLE` waits for a burst start. `ST_COLLECT` gathers word results. Three transitions are named. Open goes from `ST_IDLE` to `ST_COLLECT` on a start. Restart goes from `ST_COLLECT` back to `ST_COLLECT` on a start, and drops the unfinished burst. Close goes from `ST_COLLECT` to `ST_IDLE` on an end strobe, and classifies the burst.

Top module: `burst_ecc_classifier`

## Requirements
- R1: Word results use the code 0 = no error, 1 = single-bit corrected, 2 = double-bit detected, and 3 is handled the same as 2. The n-th accepted word of a burst (n counted from 0) owns bit n of the error mask.
- R2: A burst in which exactly one word carries code 1 and no word carries code 2 or 3 sets irq_corr at the clock edge that samples burst_end. irq_fatal is left unchanged.
- R3: A burst in which any word carries code 2 or 3 sets irq_fatal at the clock edge that samples burst_end.
- R4: A burst in which two or more words carry code 1 sets irq_fatal and does not set irq_corr.
- R5: A burst with no error words raises no interrupt and leaves the log unchanged.
- R6: While no fatal record is held, every correctable or fatal event loads the log. log_addr is loaded with the burst address with bits [5:0] cleared. log_mask is loaded with one bit per 16-byte word over the 8 words of a 128-byte block, and a bit is set for any word with code 1, 2 or 3.
- R7: Once a fatal event is logged, the log stays frozen against later events. A fatal event that arrives while the log is frozen sets log_overflow.
- R8: Each interrupt stays high until its acknowledge pulse (ack_corr or ack_fatal), which clears it at the next edge. An acknowledge in the same cycle as a new event of that kind leaves the interrupt set.
- R9: ack_fatal unfreezes the log and clears log_overflow. If a fatal event arrives in the same cycle, the log is reloaded from that new event and log_overflow stays clear.
- R10: A burst_start that arrives while a burst is still open discards that burst without reporting it, and begins a new burst.
- R11: The following strobes are ignored: word strobes beyond the eighth word of a burst, a word strobe in the same cycle as burst_start, and word or end strobes given while no burst is open.
- R12: After reset, both interrupts, log_overflow, log_addr and log_mask are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_start | input | 1 | Opens a new burst and captures burst_addr |
| burst_addr | input | ADDR_W | Byte address of the burst |
| word_valid | input | 1 | A word check result is present |
| word_status | input | 2 | Word check result code (R1) |
| burst_end | input | 1 | Closes the open burst and triggers classification |
| ack_corr | input | 1 | Clear pulse for irq_corr |
| ack_fatal | input | 1 | Clear pulse for irq_fatal, the log freeze and overflow |
| irq_corr | output | 1 | Correctable-event interrupt, level |
| irq_fatal | output | 1 | Fatal-event interrupt, level |
| log_addr | output | ADDR_W | Logged address, 64-byte aligned |
| log_mask | output | 8 | Logged per-word error mask |
| log_overflow | output | 1 | A fatal event arrived while the log was frozen |

## Verification
Bursts are driven with no errors, with one single-bit word, with a double word or code 3 in different positions, and with single-bit words spread over two positions. These patterns separate the clean, correctable, escalated and detected-fatal classes, and each class is checked in both the interrupts and the mask bit positions. The same patterns are repeated while a fatal record is held, and while an acknowledge lands in the closing cycle, so that freeze, overflow and the set-over-clear priority each have an observable effect. Restarted bursts, over-long bursts, a word in the start cycle and strobes outside a burst carry double-bit codes, so that any leak of them would appear as a spurious fatal event.

// File: rtl/becc_pkg.sv
package becc_pkg;

    typedef enum logic [1:0] {
        WS_CLEAN    = 2'd0,
        WS_SINGLE   = 2'd1,
        WS_DOUBLE   = 2'd2,
        WS_RESERVED = 2'd3
    } word_stat_e;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } burst_state_e;

    typedef enum logic [1:0] {
        CL_CLEAN = 2'd0,
        CL_CORR  = 2'd1,
        CL_FATAL = 2'd2
    } burst_class_e;

endpackage

// File: rtl/becc_word_track.sv
module becc_word_track
    import becc_pkg::*;
#(
    parameter int WORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             collect,
    input  logic             word_valid,
    input  logic [1:0]       word_status,
    output logic [WORDS-1:0] sbe_next,
    output logic [WORDS-1:0] dbe_next
);
    localparam int IDX_W = $clog2(WORDS + 1);

    logic [IDX_W-1:0] idx_q;
    logic [WORDS-1:0] sbe_q;
    logic [WORDS-1:0] dbe_q;
    logic             accept;
    logic [WORDS-1:0] hit;
    word_stat_e       stat;

    assign stat   = word_stat_e'(word_status);
    assign accept = collect && word_valid && (idx_q < IDX_W'(WORDS));
    assign hit    = accept ? (WORDS'(1) << idx_q) : '0;

    always_comb begin
        sbe_next = sbe_q;
        dbe_next = dbe_q;
        unique case (stat)
            WS_SINGLE:              sbe_next = sbe_q | hit;
            WS_DOUBLE, WS_RESERVED: dbe_next = dbe_q | hit;
            default:                ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            sbe_q <= '0;
            dbe_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
            sbe_q <= '0;
            dbe_q <= '0;
        end else begin
            sbe_q <= sbe_next;
            dbe_q <= dbe_next;
            if (accept) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/becc_burst_fsm.sv
module becc_burst_fsm
    import becc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 6,
    parameter int WORDS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic              burst_end,
    input  logic [ADDR_W-1:0] burst_addr,
    input  logic [WORDS-1:0]  sbe_next,
    input  logic [WORDS-1:0]  dbe_next,
    output logic              collect,
    output logic              evt_valid,
    output logic              evt_fatal,
    output logic [ADDR_W-1:0] evt_addr,
    output logic [WORDS-1:0]  evt_mask
);
    burst_state_e      state_q;
    burst_state_e      state_d;
    logic [ADDR_W-1:0] addr_q;
    burst_class_e      cls;
    logic              multi_sbe;

    // state register and burst address capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (burst_start) begin
                addr_q <= {burst_addr[ADDR_W-1:ALIGN_W], ALIGN_W'(0)};
            end
        end
    end

    // transitions: open, restart, close
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (burst_start) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (burst_start)    state_d = ST_COLLECT;
                else if (burst_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign multi_sbe = (sbe_next & (sbe_next - WORDS'(1))) != '0;

    // outputs: collect window and burst classification on close
    always_comb begin
        collect = 1'b0;
        cls     = CL_CLEAN;
        unique case (state_q)
            ST_IDLE: ;
            ST_COLLECT: begin
                collect = !burst_start;
                if (!burst_start && burst_end) begin
                    if ((dbe_next != '0) || multi_sbe) cls = CL_FATAL;
                    else if (sbe_next != '0)           cls = CL_CORR;
                end
            end
            default: ;
        endcase
        evt_valid = (cls != CL_CLEAN);
        evt_fatal = (cls == CL_FATAL);
        evt_addr  = addr_q;
        evt_mask  = sbe_next | dbe_next;
    end

endmodule

// File: rtl/becc_event_log.sv
module becc_event_log #(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic              evt_fatal,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [WORDS-1:0]  evt_mask,
    input  logic              ack_fatal,
    output logic [ADDR_W-1:0] log_addr,
    output logic [WORDS-1:0]  log_mask,
    output logic              log_overflow
);
    logic frozen_q;
    logic capture;

    assign capture = evt_valid && (!frozen_q || ack_fatal);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frozen_q     <= 1'b0;
            log_addr     <= '0;
            log_mask     <= '0;
            log_overflow <= 1'b0;
        end else begin
            if (capture) begin
                log_addr <= evt_addr;
                log_mask <= evt_mask;
            end
            if (evt_fatal)      frozen_q <= 1'b1;
            else if (ack_fatal) frozen_q <= 1'b0;
            if (ack_fatal)                  log_overflow <= 1'b0;
            else if (evt_fatal && frozen_q) log_overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/becc_irq_latch.sv
module becc_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   irq <= 1'b0;
        else if (set) irq <= 1'b1;
        else if (clr) irq <= 1'b0;
    end
endmodule

// File: rtl/burst_ecc_classifier.sv
module burst_ecc_classifier #(
    parameter int ADDR_W      = 32,
    parameter int ALIGN_BYTES = 64,
    parameter int WORD_BYTES  = 16,
    localparam int WORDS      = (2 * ALIGN_BYTES) / WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic [ADDR_W-1:0] burst_addr,
    input  logic              word_valid,
    input  logic [1:0]        word_status,
    input  logic              burst_end,
    input  logic              ack_corr,
    input  logic              ack_fatal,
    output logic              irq_corr,
    output logic              irq_fatal,
    output logic [ADDR_W-1:0] log_addr,
    output logic [WORDS-1:0]  log_mask,
    output logic              log_overflow
);
    localparam int ALIGN_W = $clog2(ALIGN_BYTES);

    logic              collect;
    logic [WORDS-1:0]  sbe_next;
    logic [WORDS-1:0]  dbe_next;
    logic              evt_valid;
    logic              evt_fatal;
    logic [ADDR_W-1:0] evt_addr;
    logic [WORDS-1:0]  evt_mask;

    becc_word_track #(.WORDS(WORDS)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (burst_start),
        .collect     (collect),
        .word_valid  (word_valid),
        .word_status (word_status),
        .sbe_next    (sbe_next),
        .dbe_next    (dbe_next)
    );

    becc_burst_fsm #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .WORDS(WORDS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_start (burst_start),
        .burst_end   (burst_end),
        .burst_addr  (burst_addr),
        .sbe_next    (sbe_next),
        .dbe_next    (dbe_next),
        .collect     (collect),
        .evt_valid   (evt_valid),
        .evt_fatal   (evt_fatal),
        .evt_addr    (evt_addr),
        .evt_mask    (evt_mask)
    );

    becc_event_log #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_valid    (evt_valid),
        .evt_fatal    (evt_fatal),
        .evt_addr     (evt_addr),
        .evt_mask     (evt_mask),
        .ack_fatal    (ack_fatal),
        .log_addr     (log_addr),
        .log_mask     (log_mask),
        .log_overflow (log_overflow)
    );

    becc_irq_latch u_irq_corr (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt_valid && !evt_fatal),
        .clr   (ack_corr),
        .irq   (irq_corr)
    );

    becc_irq_latch u_irq_fatal (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt_fatal),
        .clr   (ack_fatal),
        .irq   (irq_fatal)
    );

endmodule

// File: rtl/becc_checker.sv
module becc_checker #(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 6,
    parameter int WORDS   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              burst_end,
    input logic              ack_corr,
    input logic              ack_fatal,
    input logic              irq_corr,
    input logic              irq_fatal,
    input logic [ADDR_W-1:0] log_addr,
    input logic [WORDS-1:0]  log_mask,
    input logic              log_overflow
);
    a_r2_corr_rise_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_corr) |-> $past(burst_end));

    a_r3_fatal_rise_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_fatal) |-> $past(burst_end));

    a_r6_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        log_addr[ALIGN_W-1:0] == '0);

    a_r7_log_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fatal && !ack_fatal) |=> ($stable(log_addr) && $stable(log_mask)));

    a_r7_overflow_needs_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        log_overflow |-> irq_fatal);

    a_r8_corr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_corr && !ack_corr) |=> irq_corr);

    a_r8_fatal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fatal && !ack_fatal) |=> irq_fatal);

    a_r8_corr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_corr && !burst_end) |=> !irq_corr);

    a_r9_fatal_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fatal && !burst_end) |=> (!irq_fatal && !log_overflow));

endmodule

bind burst_ecc_classifier becc_checker #(
    .ADDR_W  (ADDR_W),
    .ALIGN_W ($clog2(ALIGN_BYTES)),
    .WORDS   (WORDS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_end    (burst_end),
    .ack_corr     (ack_corr),
    .ack_fatal    (ack_fatal),
    .irq_corr     (irq_corr),
    .irq_fatal    (irq_fatal),
    .log_addr     (log_addr),
    .log_mask     (log_mask),
    .log_overflow (log_overflow)
);

// File: tb/burst_ecc_classifier_test.sv
`timescale 1ns/1ps
module burst_ecc_classifier_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_start = 1'b0;
    logic [31:0] burst_addr = '0;
    logic        word_valid = 1'b0;
    logic [1:0]  word_status = 2'd0;
    logic        burst_end = 1'b0;
    logic        ack_corr = 1'b0;
    logic        ack_fatal = 1'b0;
    logic        irq_corr;
    logic        irq_fatal;
    logic [31:0] log_addr;
    logic [7:0]  log_mask;
    logic        log_overflow;

    always #10 clk = ~clk;

    burst_ecc_classifier uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_start  (burst_start),
        .burst_addr   (burst_addr),
        .word_valid   (word_valid),
        .word_status  (word_status),
        .burst_end    (burst_end),
        .ack_corr     (ack_corr),
        .ack_fatal    (ack_fatal),
        .irq_corr     (irq_corr),
        .irq_fatal    (irq_fatal),
        .log_addr     (log_addr),
        .log_mask     (log_mask),
        .log_overflow (log_overflow)
    );

    typedef struct {
        logic        c;
        logic        f;
        logic        ovf;
        logic [31:0] a;
        logic [7:0]  m;
        string       tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_checks = 0;
    int   n_fail   = 0;

    // reference model state
    logic        m_corr = 1'b0;
    logic        m_fatal = 1'b0;
    logic        m_ovf = 1'b0;
    logic [31:0] m_addr = '0;
    logic [7:0]  m_mask = '0;

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "irq_corr",     32'(irq_corr),     32'(e.c));
                cmp(e.tag, "irq_fatal",    32'(irq_fatal),    32'(e.f));
                cmp(e.tag, "log_overflow", 32'(log_overflow), 32'(e.ovf));
                cmp(e.tag, "log_addr",     log_addr,          e.a);
                cmp(e.tag, "log_mask",     32'(log_mask),     32'(e.m));
            end
        end
    end

    task automatic push_check(input string tag);
        exp_t e;
        e.c = m_corr; e.f = m_fatal; e.ovf = m_ovf;
        e.a = m_addr; e.m = m_mask; e.tag = tag;
        q.push_back(e);
        ->chk_ev;
        #1;
    endtask

    // model of a burst close with optional acknowledges in the same cycle
    task automatic model_close(input logic [31:0] addr, input logic [19:0] sts,
                               input int n, input bit ackc, input bit ackf);
        logic [7:0] sm = '0;
        logic [7:0] dm = '0;
        int         sc = 0;
        bit         fat, cor, cap;
        for (int i = 0; i < n && i < 8; i++) begin
            if (sts[2*i +: 2] == 2'd1) begin sm[i] = 1'b1; sc++; end
            else if (sts[2*i +: 2] >= 2'd2) dm[i] = 1'b1;
        end
        fat = (dm != 0) || (sc >= 2);
        cor = !fat && (sc == 1);
        cap = (fat || cor) && (!m_fatal || ackf);
        if (cap) begin
            m_addr = {addr[31:6], 6'd0};
            m_mask = sm | dm;
        end
        if (ackf)                m_ovf = 1'b0;
        else if (fat && m_fatal) m_ovf = 1'b1;
        if (fat)       m_fatal = 1'b1;
        else if (ackf) m_fatal = 1'b0;
        if (cor)       m_corr = 1'b1;
        else if (ackc) m_corr = 1'b0;
    endtask

    task automatic open_words(input logic [31:0] addr, input logic [19:0] sts,
                              input int n, input bit junk_start);
        @(negedge clk);
        burst_start = 1'b1; burst_addr = addr;
        word_valid = junk_start; word_status = 2'd2;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            burst_start = 1'b0; word_valid = 1'b1; word_status = sts[2*i +: 2];
        end
    endtask

    task automatic run_burst(input logic [31:0] addr, input logic [19:0] sts,
                             input int n, input bit junk_start,
                             input bit ackc, input bit ackf, input string tag);
        open_words(addr, sts, n, junk_start);
        @(negedge clk);
        burst_start = 1'b0; word_valid = 1'b0; burst_end = 1'b1;
        ack_corr = ackc; ack_fatal = ackf;
        model_close(addr, sts, n, ackc, ackf);
        @(negedge clk);
        burst_end = 1'b0; ack_corr = 1'b0; ack_fatal = 1'b0;
        push_check(tag);
    endtask

    task automatic do_ack(input bit ackc, input bit ackf, input string tag);
        @(negedge clk);
        ack_corr = ackc; ack_fatal = ackf;
        if (ackc) m_corr = 1'b0;
        if (ackf) begin m_fatal = 1'b0; m_ovf = 1'b0; end
        @(negedge clk);
        ack_corr = 1'b0; ack_fatal = 1'b0;
        push_check(tag);
    endtask

    task automatic stray_strobes(input string tag);
        @(negedge clk);
        burst_end = 1'b1; word_valid = 1'b1; word_status = 2'd2;
        @(negedge clk);
        burst_end = 1'b0; word_valid = 1'b0;
        @(negedge clk);
        push_check(tag);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_check("R12 reset state");

        // R5 / R1: clean burst, no report
        run_burst(32'h0000_1000, 20'h0, 8, 1'b0, 1'b0, 1'b0, "R5 clean burst");
        // R2 / R6: one single-bit word at position 3, unaligned address
        run_burst(32'h1234_567F, 20'h00040, 8, 1'b0, 1'b0, 1'b0, "R2 R6 single word3");
        // R8: acknowledge correctable
        do_ack(1'b1, 1'b0, "R8 ack_corr clears");
        // R3: double at word 5
        run_burst(32'h0000_2040, 20'h00800, 8, 1'b0, 1'b0, 1'b0, "R3 double word5");
        // R7: correctable while frozen leaves log alone
        run_burst(32'h0000_3000, 20'h00001, 8, 1'b0, 1'b0, 1'b0, "R7 corr while frozen");
        // R7 / R4: escalated fatal while frozen sets overflow
        run_burst(32'h0000_4000, 20'h00005, 8, 1'b0, 1'b0, 1'b0, "R7 overflow");
        // R9: acknowledge everything
        do_ack(1'b1, 1'b1, "R9 ack_fatal releases");
        // R4: singles at words 1 and 6
        run_burst(32'h0000_5080, 20'h01004, 8, 1'b0, 1'b0, 1'b0, "R4 two singles escalate");
        // R8 / R9 / R1: ack_fatal with a new fatal (code 3 at word 7) in same cycle
        run_burst(32'h0000_6100, 20'h0C000, 8, 1'b0, 1'b0, 1'b1, "R8 R9 ack with new fatal");
        do_ack(1'b0, 1'b1, "R9 ack_fatal after collision");
        // R8: ack_corr in the closing cycle of a correctable burst
        run_burst(32'h0000_7000, 20'h00004, 8, 1'b0, 1'b1, 1'b0, "R8 ack_corr with new corr");
        do_ack(1'b1, 1'b0, "R8 ack_corr again");
        // R10: unfinished burst with a double is discarded by a restart
        open_words(32'h0000_8000, 20'h0000A, 3, 1'b0);
        run_burst(32'h0000_9000, 20'h00010, 8, 1'b0, 1'b0, 1'b0, "R10 restart discards");
        do_ack(1'b1, 1'b0, "R10 ack");
        // R11: doubles beyond word 8, and in the start cycle, are ignored
        run_burst(32'h0000_A000, 20'hA0100, 10, 1'b1, 1'b0, 1'b0, "R11 extra words ignored");
        // R11: strobes outside a burst are ignored
        stray_strobes("R11 strobes outside burst");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule